// File: doc/BRIEF.md
# Asynchronous Static Memory Timing Engine

This block connects an internal request port to one shared external bus that serves several asynchronous static memories or memory-mapped peripherals. Each device has its own chip-select line. Address, data, byte-lane and strobe lines are common to all devices. The engine handles one access at a time. It takes a request over a valid/ready handshake and steps it through a sequence of timed phases. Each phase lasts a programmed number of clock cycles.

Reads and writes each have their own timing set: address setup, address hold, data setup, data hold and bus turnaround. A single byte-lane lead time, shared by both, opens every access. In multiplexed mode, the low address bits first travel on the data lines, framed by an address-valid strobe. A narrow mode uses only the low byte lane. During data setup, an external wait line with selectable polarity can stretch the access.

The data bus is presented as separate output, output-enable and input vectors, so that the pad ring or an FPGA I/O buffer builds the tri-state driver.

Top module: `asmc_engine`

## Requirements
- R1: `req_ready` is high only when no access is in progress. After acceptance it stays low for exactly B+A+AH+D+H+T cycles. These are byte-lane lead, address setup, address hold (0 unless multiplexed), effective data setup, data hold and turnaround.
- R2: The phases run in this order: byte-lane lead, address setup, address hold, data setup, data hold, turnaround. Byte lanes go low B cycles before the chip select. The chip select stays low for A+AH+D+H cycles. For reads, `mem_oe_n` is low for D cycles.
- R3: `mem_adv_n` is low for the A address-setup cycles. With `cfg_mux`=1, `mem_dq_o` carries `req_addr[DW-1:0]` through address setup and address hold. With `cfg_mux`=0, the address-hold count has no effect on any output.
- R4: A write takes every count from `cfg_wr_tim` and a read from `cfg_rd_tim`. Each is packed with address setup in [CW-1:0], address hold next, then data setup, then data hold, and turnaround in the top field. During a write, `mem_we_n` is low for D cycles, `mem_oe_n` stays high, and `mem_dq_o` holds the write data.
- R5: A zero count removes its phase entirely. A data-setup count of zero still yields one data-setup cycle.
- R6: With `cfg_async_wait`=1, data setup is extended by one cycle for every clock edge at which `mem_wait` is at its active level. The active level is low when `cfg_wait_hi`=0 and high when it is 1. With `cfg_async_wait`=0, `mem_wait` has no effect.
- R7: A read captures `mem_dq_i` on the last data-setup cycle. The engine returns the captured value with a one-cycle `rsp_valid` pulse in the cycle after `mem_oe_n` rises. A write produces no pulse.
- R8: `mem_dq_oe` is high only in the address phases of a multiplexed access and in the data-setup and data-hold phases of a write. It is never high while `mem_oe_n` is low.
- R9: With `cfg_bus16`=0, `mem_be_n[1]` stays high and only `req_be[0]` is used. Only the low data byte is written. `rsp_rdata[15:8]` reads as zero.
- R10: During an access, only the chip select numbered `req_cs` goes low. `mem_addr` holds the request address, and `mem_be_n` is the inverse of the used byte strobes.
- R11: After reset, `req_ready` is high and `rsp_valid` is low. All chip selects, byte lanes and strobes are high, and `mem_dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Device address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte strobes, active high |
| req_cs | input | clog2(NCS) | Target device index |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | DW | Captured read data |
| cfg_mux | input | 1 | Address/data multiplexed on data lines |
| cfg_bus16 | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_wait_hi | input | 1 | Wait line active high when 1 |
| cfg_async_wait | input | 1 | Honour wait line during data setup |
| cfg_bls | input | CW | Byte-lane lead cycles |
| cfg_rd_tim | input | 5*CW | Read timing set |
| cfg_wr_tim | input | 5*CW | Write timing set |
| mem_cs_n | output | NCS | Chip selects, active low |
| mem_be_n | output | DW/8 | Byte-lane enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW | Address bus |
| mem_dq_o | output | DW | Data bus output value |
| mem_dq_oe | output | 1 | Data bus driver enable |
| mem_dq_i | input | DW | Data bus input value |
| mem_wait | input | 1 | Device wait line |

## Verification
Two functions can fall in the same cycle: the end of data setup, which is also the read capture, and a wait assertion that must hold it back. The bench asserts the wait line at its programmed level on the negative edge in the first data-setup cycle. It keeps the line asserted for a set number of edges, so a hold collides with a counter that has already expired. It also drives `mem_dq_i` with a value that changes in every output-enable cycle. The bench judges the result by the number of output-enable cycles, which must equal data setup plus the wait edges, and by the returned word. That word must be the one present on the final enabled cycle, not an earlier one.

// File: rtl/asmc_pkg.sv
package asmc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_BLS,
    PH_ASET,
    PH_AHLD,
    PH_DSET,
    PH_DHLD,
    PH_TURN
  } phase_e;
endpackage

// File: rtl/asmc_phase_seq.sv
module asmc_phase_seq
  import asmc_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mux,
  input  logic          wait_act,
  input  logic [CW-1:0] t_bls,
  input  logic [CW-1:0] t_as,
  input  logic [CW-1:0] t_ah,
  input  logic [CW-1:0] t_ds,
  input  logic [CW-1:0] t_dh,
  input  logic [CW-1:0] t_ta,
  output phase_e        phase,
  output phase_e        phase_nxt,
  output logic          dset_done
);
  logic [CW-1:0] cnt, cnt_nxt;

  // first phase with a nonzero length at or after each point of the sequence
  phase_e at_turn, at_dhld, at_ahld, at_aset, at_bls;
  assign at_turn = (|t_ta) ? PH_TURN : PH_IDLE;
  assign at_dhld = (|t_dh) ? PH_DHLD : at_turn;
  assign at_ahld = (mux && (|t_ah)) ? PH_AHLD : PH_DSET;
  assign at_aset = (|t_as) ? PH_ASET : at_ahld;
  assign at_bls  = (|t_bls) ? PH_BLS : at_aset;

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt;
    dset_done = 1'b0;
    case (phase)
      PH_IDLE: if (start) phase_nxt = at_bls;
      PH_DSET: begin
        if (!wait_act) begin
          if (cnt == '0) begin
            dset_done = 1'b1;
            phase_nxt = at_dhld;
          end else begin
            cnt_nxt = cnt - 1'b1;
          end
        end
      end
      default: begin
        if (cnt == '0) begin
          case (phase)
            PH_BLS:  phase_nxt = at_aset;
            PH_ASET: phase_nxt = at_ahld;
            PH_AHLD: phase_nxt = PH_DSET;
            PH_DHLD: phase_nxt = at_turn;
            default: phase_nxt = PH_IDLE;
          endcase
        end else begin
          cnt_nxt = cnt - 1'b1;
        end
      end
    endcase
    if (phase_nxt != phase) begin
      case (phase_nxt)
        PH_BLS:  cnt_nxt = t_bls - 1'b1;
        PH_ASET: cnt_nxt = t_as - 1'b1;
        PH_AHLD: cnt_nxt = t_ah - 1'b1;
        PH_DSET: cnt_nxt = (t_ds == '0) ? '0 : t_ds - 1'b1;
        PH_DHLD: cnt_nxt = t_dh - 1'b1;
        PH_TURN: cnt_nxt = t_ta - 1'b1;
        default: cnt_nxt = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/asmc_pin_drv.sv
module asmc_pin_drv
  import asmc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int NCS = 4,
  localparam int NBL = DW / 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  phase_e         phase_nxt,
  input  logic           dset_done,
  input  logic           mux,
  input  logic           bus16,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NBL-1:0] req_be,
  input  logic [CSW-1:0] req_cs,
  input  logic [DW-1:0]  mem_dq_i,
  output logic           act_wr,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic [NCS-1:0] mem_cs_n,
  output logic [NBL-1:0] mem_be_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           mem_adv_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe
);
  // request held for the whole access
  logic           h_wr;
  logic [AW-1:0]  h_addr;
  logic [DW-1:0]  h_wdata;
  logic [NBL-1:0] h_be;
  logic [CSW-1:0] h_cs;

  // fields seen by the pin decode: the incoming request on its accept cycle
  logic           f_wr;
  logic [AW-1:0]  f_addr;
  logic [DW-1:0]  f_wdata;
  logic [NBL-1:0] f_be;
  logic [CSW-1:0] f_cs;
  assign f_wr    = start ? req_write : h_wr;
  assign f_addr  = start ? req_addr  : h_addr;
  assign f_wdata = start ? req_wdata : h_wdata;
  assign f_be    = start ? req_be    : h_be;
  assign f_cs    = start ? req_cs    : h_cs;
  assign act_wr  = h_wr;

  logic           cs_win, lane_win, addr_on_dq, wr_on_dq;
  logic [NBL-1:0] be_used;
  logic [DW-1:0]  wd_used, rd_used;
  logic [NCS-1:0] cs_dec;

  assign cs_win     = phase_nxt inside {PH_ASET, PH_AHLD, PH_DSET, PH_DHLD};
  assign lane_win   = cs_win || (phase_nxt == PH_BLS);
  assign addr_on_dq = mux && (phase_nxt inside {PH_ASET, PH_AHLD});
  assign wr_on_dq   = f_wr && (phase_nxt inside {PH_DSET, PH_DHLD});
  assign be_used    = bus16 ? f_be : {{(NBL-1){1'b0}}, f_be[0]};
  assign wd_used    = bus16 ? f_wdata : {{(DW-8){1'b0}}, f_wdata[7:0]};
  assign rd_used    = bus16 ? mem_dq_i : {{(DW-8){1'b0}}, mem_dq_i[7:0]};

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      cs_dec[i] = !(cs_win && (f_cs == CSW'(i)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_wr      <= 1'b0;
      h_addr    <= '0;
      h_wdata   <= '0;
      h_be      <= '0;
      h_cs      <= '0;
      mem_cs_n  <= '1;
      mem_be_n  <= '1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (start) begin
        h_wr    <= req_write;
        h_addr  <= req_addr;
        h_wdata <= req_wdata;
        h_be    <= req_be;
        h_cs    <= req_cs;
      end
      mem_cs_n  <= cs_dec;
      mem_be_n  <= lane_win ? ~be_used : '1;
      mem_adv_n <= !(phase_nxt == PH_ASET);
      mem_oe_n  <= !((phase_nxt == PH_DSET) && !f_wr);
      mem_we_n  <= !((phase_nxt == PH_DSET) && f_wr);
      if (lane_win) mem_addr <= f_addr;
      mem_dq_oe <= addr_on_dq || wr_on_dq;
      if (addr_on_dq)    mem_dq_o <= f_addr[DW-1:0];
      else if (wr_on_dq) mem_dq_o <= wd_used;
      rsp_valid <= dset_done && !h_wr;
      if (dset_done && !h_wr) rsp_rdata <= rd_used;
    end
  end
endmodule

// File: rtl/asmc_engine.sv
module asmc_engine
  import asmc_pkg::*;
#(
  parameter int AW  = 24,
  parameter int DW  = 16,
  parameter int NCS = 4,
  parameter int CW  = 4,
  localparam int NBL = DW / 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int TW  = 5 * CW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [NBL-1:0] req_be,
  input  logic [CSW-1:0] req_cs,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  input  logic           cfg_mux,
  input  logic           cfg_bus16,
  input  logic           cfg_wait_hi,
  input  logic           cfg_async_wait,
  input  logic [CW-1:0]  cfg_bls,
  input  logic [TW-1:0]  cfg_rd_tim,
  input  logic [TW-1:0]  cfg_wr_tim,
  output logic [NCS-1:0] mem_cs_n,
  output logic [NBL-1:0] mem_be_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           mem_adv_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dq_o,
  output logic           mem_dq_oe,
  input  logic [DW-1:0]  mem_dq_i,
  input  logic           mem_wait
);
  phase_e        phase, phase_nxt;
  logic          start, dset_done, act_wr, sel_wr, wait_act;
  logic [TW-1:0] tim;

  assign req_ready = (phase == PH_IDLE);
  assign start     = req_valid && req_ready;
  assign sel_wr    = start ? req_write : act_wr;
  assign tim       = sel_wr ? cfg_wr_tim : cfg_rd_tim;
  assign wait_act  = cfg_async_wait && (mem_wait == cfg_wait_hi);

  asmc_phase_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .mux       (cfg_mux),
    .wait_act  (wait_act),
    .t_bls     (cfg_bls),
    .t_as      (tim[0*CW +: CW]),
    .t_ah      (tim[1*CW +: CW]),
    .t_ds      (tim[2*CW +: CW]),
    .t_dh      (tim[3*CW +: CW]),
    .t_ta      (tim[4*CW +: CW]),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .dset_done (dset_done)
  );

  asmc_pin_drv #(.AW(AW), .DW(DW), .NCS(NCS)) u_pins (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase_nxt (phase_nxt),
    .dset_done (dset_done),
    .mux       (cfg_mux),
    .bus16     (cfg_bus16),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .req_cs    (req_cs),
    .mem_dq_i  (mem_dq_i),
    .act_wr    (act_wr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_cs_n  (mem_cs_n),
    .mem_be_n  (mem_be_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_adv_n (mem_adv_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );
endmodule

// File: rtl/asmc_engine_sva.sv
module asmc_engine_sva #(
  parameter int NCS = 4,
  parameter int NBL = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_ready,
  input logic           rsp_valid,
  input logic           cfg_bus16,
  input logic [NCS-1:0] mem_cs_n,
  input logic [NBL-1:0] mem_be_n,
  input logic           mem_oe_n,
  input logic           mem_we_n,
  input logic           mem_adv_n,
  input logic           mem_dq_oe
);
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~mem_cs_n));

  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && !mem_we_n));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r7_rsp_after_oe: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (mem_oe_n && !$past(mem_oe_n)));

  a_r7_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r2_strobes_in_select: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || !mem_we_n || !mem_adv_n) |-> (mem_cs_n != '1));

  a_r9_narrow_lane: assert property (@(posedge clk) disable iff (rst)
    !cfg_bus16 |-> mem_be_n[NBL-1]);
endmodule

bind asmc_engine asmc_engine_sva #(.NCS(NCS), .NBL(NBL)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .cfg_bus16 (cfg_bus16),
  .mem_cs_n  (mem_cs_n),
  .mem_be_n  (mem_be_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_adv_n (mem_adv_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/asmc_engine_test.sv
module asmc_engine_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic [1:0]  req_cs = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        cfg_mux = 1'b0, cfg_bus16 = 1'b1, cfg_wait_hi = 1'b0, cfg_async_wait = 1'b0;
  logic [3:0]  cfg_bls = '0;
  logic [19:0] cfg_rd_tim = '0, cfg_wr_tim = '0;
  logic [3:0]  mem_cs_n;
  logic [1:0]  mem_be_n;
  logic        mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [23:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i = '0;
  logic        mem_wait = 1'b1;

  always #(CLK_P/2) clk = ~clk;

  asmc_engine uut (.*);

  int tests = 0, fails = 0;

  // monitor state
  bit   mon_en = 0;
  int   n_busy, n_bls, n_cs, n_adv, n_oe, n_we, n_dqoe, n_rsp, n_be1;
  int   bad_cs, bad_addr, bad_be, bad_mux, bad_wd, bad_rsp;
  int   got_rd;
  int   wait_left = 0;
  bit   prev_oe_low = 0;
  logic [23:0] e_addr;
  logic [15:0] e_wd, rd_base;
  logic [1:0]  e_be;
  logic [1:0]  e_cs;

  always @(negedge clk) begin
    bit act;
    if (mon_en) begin
      if (!req_ready) n_busy++;
      if (mem_cs_n == 4'hF && mem_be_n != 2'b11) n_bls++;
      if (mem_cs_n != 4'hF) begin
        n_cs++;
        if ($countones(~mem_cs_n) != 1 || mem_cs_n[e_cs]) bad_cs++;
        if (mem_addr != e_addr) bad_addr++;
      end
      if (mem_be_n != 2'b11 && mem_be_n != ~e_be) bad_be++;
      if (!mem_be_n[1]) n_be1++;
      if (!mem_adv_n) begin
        n_adv++;
        if (cfg_mux && (!mem_dq_oe || mem_dq_o != e_addr[15:0])) bad_mux++;
      end
      if (!mem_oe_n) n_oe++;
      if (!mem_we_n) begin
        n_we++;
        if (!mem_dq_oe || mem_dq_o != e_wd) bad_wd++;
      end
      if (mem_dq_oe) n_dqoe++;
      if (rsp_valid) begin
        n_rsp++;
        got_rd = int'(rsp_rdata);
        if (!prev_oe_low || !mem_oe_n) bad_rsp++;
      end
    end
    prev_oe_low = !mem_oe_n;
    act = 0;
    if (!mem_oe_n && wait_left > 0) begin
      act = 1;
      wait_left--;
    end
    mem_wait = cfg_wait_hi ? act : !act;
    mem_dq_i = !mem_oe_n ? (rd_base + 16'(n_oe)) : 16'hDEAD;
  end

  task automatic chk(input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [19:0] tim(input int as_c, input int ah_c, input int ds_c,
                                      input int dh_c, input int ta_c);
    return {4'(ta_c), 4'(dh_c), 4'(ds_c), 4'(ah_c), 4'(as_c)};
  endfunction

  task automatic do_access(input bit wr, input logic [23:0] a, input logic [15:0] wd,
                           input logic [1:0] be, input logic [1:0] cs, input int wt);
    int guard;
    @(posedge clk); #1;
    n_busy = 0; n_bls = 0; n_cs = 0; n_adv = 0; n_oe = 0; n_we = 0; n_dqoe = 0;
    n_rsp = 0; n_be1 = 0; bad_cs = 0; bad_addr = 0; bad_be = 0; bad_mux = 0;
    bad_wd = 0; bad_rsp = 0; got_rd = -1;
    e_addr = a; e_cs = cs;
    e_be = cfg_bus16 ? be : {1'b0, be[0]};
    e_wd = cfg_bus16 ? wd : {8'h00, wd[7:0]};
    wait_left = wt;
    req_write = wr; req_addr = a; req_wdata = wd; req_be = be; req_cs = cs;
    req_valid = 1'b1; mon_en = 1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    guard = 0;
    while (!req_ready && guard < 200) begin
      @(posedge clk); #1;
      guard++;
    end
    if (guard >= 200) chk("R1 access completes", 0, 1);
    repeat (2) @(posedge clk);
    #1 mon_en = 0;
  endtask

  task automatic judge(input bit wr, input int b, input int a, input int ah,
                       input int d, input int h, input int t);
    chk("R2 byte-lane lead cycles", n_bls, b);
    chk("R2 chip-select span", n_cs, a + ah + d + h);
    chk("R3 address strobe cycles", n_adv, a);
    chk(wr ? "R4 write strobe cycles" : "R2 read strobe cycles", wr ? n_we : n_oe, d);
    chk("R4 idle opposite strobe", wr ? n_oe : n_we, 0);
    chk("R1 busy span", n_busy, b + a + ah + d + h + t);
    chk("R8 data drive cycles", n_dqoe, (cfg_mux ? a + ah : 0) + (wr ? d + h : 0));
    chk("R10 select and address", bad_cs + bad_addr, 0);
    chk("R10 byte-lane value", bad_be, 0);
    chk("R3 address on data lines", bad_mux, 0);
    chk("R4 write data on bus", bad_wd, 0);
    chk("R7 response pulses", n_rsp, wr ? 0 : 1);
    if (!wr) begin
      chk("R7 captured word", got_rd,
          cfg_bus16 ? int'(16'(rd_base + 16'(d))) : int'(8'(rd_base + 16'(d))));
      chk("R7 response timing", bad_rsp, 0);
    end
    if (!cfg_bus16) chk("R9 upper lane idle", n_be1, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R11 ready after reset", int'(req_ready), 1);
    chk("R11 selects and lanes high", int'({mem_cs_n, mem_be_n}), 63);
    chk("R11 strobes high", int'({mem_oe_n, mem_we_n, mem_adv_n}), 7);
    chk("R11 no drive, no response", int'({mem_dq_oe, rsp_valid}), 0);
  endtask

  task automatic t_read_basic;  // R2 R3 (hold ignored) R10
    cfg_mux = 0; cfg_bus16 = 1; cfg_bls = 2;
    cfg_rd_tim = tim(3, 2, 2, 1, 2); cfg_wr_tim = tim(1, 1, 1, 1, 1);
    rd_base = 16'h1000;
    do_access(0, 24'h12_3456, 16'h0, 2'b11, 2'd1, 0);
    judge(0, 2, 3, 0, 2, 1, 2);
  endtask

  task automatic t_write_set;  // R4
    cfg_mux = 0; cfg_bls = 1;
    cfg_rd_tim = tim(5, 0, 5, 5, 5); cfg_wr_tim = tim(1, 0, 3, 2, 1);
    do_access(1, 24'h00_0A0A, 16'hBEEF, 2'b11, 2'd2, 0);
    judge(1, 1, 1, 0, 3, 2, 1);
  endtask

  task automatic t_mux_read;  // R3 R5
    cfg_mux = 1; cfg_bls = 0;
    cfg_rd_tim = tim(2, 2, 1, 0, 0);
    rd_base = 16'h2200;
    do_access(0, 24'hAB_CDEF, 16'h0, 2'b11, 2'd0, 0);
    judge(0, 0, 2, 2, 1, 0, 0);
  endtask

  task automatic t_mux_write;  // R3 R8
    cfg_mux = 1; cfg_bls = 1;
    cfg_wr_tim = tim(1, 1, 2, 1, 1);
    do_access(1, 24'h01_7711, 16'h5AA5, 2'b11, 2'd3, 0);
    judge(1, 1, 1, 1, 2, 1, 1);
  endtask

  task automatic t_zero;  // R5
    cfg_mux = 0; cfg_bls = 0;
    cfg_rd_tim = tim(0, 0, 0, 0, 0);
    rd_base = 16'h3300;
    do_access(0, 24'h00_0001, 16'h0, 2'b11, 2'd1, 0);
    judge(0, 0, 0, 0, 1, 0, 0);
  endtask

  task automatic t_wait_low;  // R6 active low
    cfg_mux = 0; cfg_bls = 0; cfg_async_wait = 1; cfg_wait_hi = 0;
    cfg_rd_tim = tim(1, 0, 2, 1, 1);
    rd_base = 16'h4400;
    do_access(0, 24'h00_0100, 16'h0, 2'b11, 2'd0, 3);
    judge(0, 0, 1, 0, 5, 1, 1);
  endtask

  task automatic t_wait_high;  // R6 active high
    cfg_async_wait = 1; cfg_wait_hi = 1;
    rd_base = 16'h5500;
    do_access(0, 24'h00_0200, 16'h0, 2'b11, 2'd0, 2);
    judge(0, 0, 1, 0, 4, 1, 1);
  endtask

  task automatic t_wait_off;  // R6 disabled
    cfg_async_wait = 0; cfg_wait_hi = 0;
    rd_base = 16'h6600;
    do_access(0, 24'h00_0300, 16'h0, 2'b11, 2'd0, 3);
    judge(0, 0, 1, 0, 2, 1, 1);
  endtask

  task automatic t_narrow;  // R9
    cfg_bus16 = 0; cfg_mux = 0; cfg_bls = 1;
    cfg_rd_tim = tim(1, 0, 2, 0, 1); cfg_wr_tim = tim(1, 0, 1, 1, 0);
    rd_base = 16'h77F0;
    do_access(0, 24'h00_0400, 16'h0, 2'b11, 2'd3, 0);
    judge(0, 1, 1, 0, 2, 0, 1);
    do_access(1, 24'h00_0401, 16'hABCD, 2'b11, 2'd3, 0);
    judge(1, 1, 1, 0, 1, 1, 0);
    cfg_bus16 = 1;
  endtask

  task automatic t_lanes;  // R10 partial strobes
    cfg_bls = 3;
    cfg_rd_tim = tim(1, 0, 1, 1, 0);
    rd_base = 16'h8800;
    do_access(0, 24'h00_0500, 16'h0, 2'b10, 2'd0, 0);
    judge(0, 3, 1, 0, 1, 1, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    tests++;
    $display("FAIL watchdog R1: got 0 expected 1 (run did not finish)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_read_basic();
    t_write_set();
    t_mux_read();
    t_mux_write();
    t_zero();
    t_wait_low();
    t_wait_high();
    t_wait_off();
    t_narrow();
    t_lanes();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule